// File: doc/BRIEF.md
# Second-Level Cache ECC Error Handler with Line Delete

This block sits on the read path of a second-level cache. Every 64-bit data word is stored with 8 check bits as a 72-bit single-error-correct, double-error-detect codeword. On each read the handler decodes the word and sorts it into one of three classes: clean, correctable or uncorrectable. It returns the corrected data and tells the cache controller what to do with the line that holds the word: purge it, invalidate it and refetch, or write it back to memory as poisoned and raise a notice that carries the failing address.

Each line index keeps a small history of the last corrected bit position. When a later correctable error on the same line hits that same bit, the line is treated as a hard fault. It is deleted for good by setting its bit in a delete mask, and any mix of lines may end up deleted. A victim selector reads the mask: it never hands out a deleted way, and it reports a forced miss when every way of a set is gone. A one-entry error log holds the first unread error and raises a sticky overflow flag when more errors arrive before the log is acknowledged.

Top module: `l2_ecc_guard`

## Requirements
- R1: Codeword layout: bit 0 is overall even parity over bits 71..1. Bits at positions 1, 2, 4, 8, 16, 32 and 64 are Hamming checks, each giving even parity over the positions whose index has that bit set. The 64 data bits fill the remaining positions in ascending order, with data bit 0 at position 3. A clean word comes back unchanged with kind 0 and no line action.
- R2: A single flipped bit at any position 0..71 comes back corrected, with kind 1, the flipped position reported on `out_pos`, and a purge of the line.
- R3: Two flipped bits give kind 2 (uncorrectable) and a purge of the line.
- R4: A correctable error on a line whose last correctable error was in the same bit position pulses `delete_o` and sets that line's bit in `dead_mask`. A correctable error in a different bit deletes nothing and replaces the stored position.
- R5: An uncorrectable error on an unmodified line (`rd_dirty`=0) pulses `refetch_o`. Neither write-back nor notification is raised.
- R6: An uncorrectable error on a modified line pulses `wb_bad_o` and `notify_o`, with `notify_addr` equal to the read's `rd_addr`. No refetch is raised.
- R7: When the log is empty, the next error loads line, word, position and kind (1 correctable, 2 uncorrectable) into it. Errors that arrive while the log is full leave its fields unchanged and set `log_ovf`. `log_ack` clears both the log and `log_ovf`.
- R8: One cycle after `alloc_req`, `alloc_way` names the lowest way of `alloc_set` whose line (set*WAYS+way) is not deleted. `alloc_miss` is 1 when all ways of the set are deleted.
- R9: Deleted lines stay deleted, in any combination. Reset clears the delete mask, the history and the log.
- R10: Every read result and line action appears exactly one clock after the `rd_valid` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | Read word present |
| rd_line | input | LW | Line index (set*WAYS+way) |
| rd_word | input | OW | Word offset within the line |
| rd_addr | input | AW | Physical address of the word |
| rd_dirty | input | 1 | Line holds modified data |
| rd_cw | input | 72 | Stored codeword |
| out_valid | output | 1 | Result valid |
| out_data | output | 64 | Corrected data |
| out_kind | output | 2 | 0 clean, 1 correctable, 2 uncorrectable |
| out_pos | output | 7 | Syndrome / corrected bit position |
| purge_o | output | 1 | Purge the line |
| delete_o | output | 1 | Line deleted permanently |
| refetch_o | output | 1 | Invalidate and refetch clean line |
| wb_bad_o | output | 1 | Write modified line back marked bad |
| notify_o | output | 1 | Failing-address notification |
| ev_line | output | LW | Line the actions refer to |
| notify_addr | output | AW | Failing address |
| dead_mask | output | LINES | One bit per deleted line |
| alloc_req | input | 1 | Victim request |
| alloc_set | input | SW | Set to allocate in |
| alloc_valid | output | 1 | Victim answer valid |
| alloc_way | output | WYW | Chosen way |
| alloc_miss | output | 1 | Every way of the set deleted |
| log_ack | input | 1 | Log read, clear it |
| log_valid | output | 1 | Log holds an error |
| log_ovf | output | 1 | Error lost while log full |
| log_line | output | LW | Logged line |
| log_word | output | OW | Logged word offset |
| log_pos | output | 7 | Logged syndrome position |
| log_kind | output | 2 | Logged error kind |

## Verification
The bench builds the block with 8 sets of 4 ways and 4 words per line, which gives 32 lines. With so few lines, repeated correctable errors can delete every way of a set, and the forced-miss answer of the victim selector can then be checked. Random reads with zero, one or two flipped bits at random positions also land on the same line often enough to test both the matching and the non-matching history cases. The small log is filled and overflowed early, so its capture, hold and acknowledge paths are covered.

// File: rtl/l2g_pkg.sv
package l2g_pkg;
  localparam int DW = 64;
  localparam int CW = 72;
  localparam int PW = 7;

  typedef enum logic [1:0] {
    EK_NONE = 2'd0,
    EK_CE   = 2'd1,
    EK_UE   = 2'd2
  } err_kind_e;

  function automatic logic is_pow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction
endpackage

// File: rtl/l2g_secded_dec.sv
module l2g_secded_dec
  import l2g_pkg::*;
(
  input  logic [CW-1:0] cw_i,
  output logic [DW-1:0] data_o,
  output err_kind_e     kind_o,
  output logic [PW-1:0] pos_o
);
  logic [PW-1:0] syn;
  logic          par;
  logic          fix;
  int            k;

  always_comb begin
    syn = '0;
    for (int p = 1; p < CW; p++)
      if (cw_i[p]) syn = syn ^ PW'(p);
    par = ^cw_i;
    fix = 1'b0;
    kind_o = EK_NONE;
    if (par) begin
      if (int'(syn) < CW) begin
        kind_o = EK_CE;
        fix = 1'b1;
      end else begin
        kind_o = EK_UE;
      end
    end else if (syn != '0) begin
      kind_o = EK_UE;
    end
    pos_o = syn;
    data_o = '0;
    k = 0;
    for (int p = 1; p < CW; p++) begin
      if (!is_pow2(p)) begin
        data_o[k] = cw_i[p] ^ (fix && (int'(syn) == p));
        k++;
      end
    end
  end
endmodule

// File: rtl/l2g_hist.sv
module l2g_hist
  import l2g_pkg::*;
#(
  parameter int LINES = 64,
  parameter int LW    = 6
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_i,
  input  logic [LW-1:0] line_i,
  input  logic [PW-1:0] pos_i,
  output logic          repeat_o
);
  logic [LINES-1:0] seen;
  logic [PW-1:0]    last_pos [LINES];

  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (ce_i) seen[line_i] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (ce_i) last_pos[line_i] <= pos_i;
  end

  assign repeat_o = ce_i && seen[line_i] && (last_pos[line_i] == pos_i);
endmodule

// File: rtl/l2g_victim.sv
module l2g_victim #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  parameter int SW   = 4,
  parameter int WYW  = 2
)(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_i,
  input  logic [SW-1:0]        set_i,
  input  logic [SETS*WAYS-1:0] dead_i,
  output logic                 valid_o,
  output logic [WYW-1:0]       way_o,
  output logic                 miss_o
);
  logic [WYW-1:0] way_n;
  logic           found;

  always_comb begin
    way_n = '0;
    found = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!dead_i[int'(set_i) * WAYS + w]) begin
        found = 1'b1;
        way_n = WYW'(w);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      way_o   <= '0;
      miss_o  <= 1'b0;
    end else begin
      valid_o <= req_i;
      if (req_i) begin
        way_o  <= way_n;
        miss_o <= !found;
      end
    end
  end
endmodule

// File: rtl/l2g_log.sv
module l2g_log
  import l2g_pkg::*;
#(
  parameter int LW = 6,
  parameter int OW = 4
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          err_i,
  input  logic [1:0]    kind_i,
  input  logic [LW-1:0] line_i,
  input  logic [OW-1:0] word_i,
  input  logic [PW-1:0] pos_i,
  input  logic          ack_i,
  output logic          valid_o,
  output logic          ovf_o,
  output logic [LW-1:0] line_o,
  output logic [OW-1:0] word_o,
  output logic [PW-1:0] pos_o,
  output logic [1:0]    kind_o
);
  logic held;
  assign held = valid_o && !ack_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      ovf_o   <= 1'b0;
      line_o  <= '0;
      word_o  <= '0;
      pos_o   <= '0;
      kind_o  <= '0;
    end else begin
      if (ack_i) ovf_o <= 1'b0;
      if (err_i) begin
        if (held) begin
          ovf_o <= 1'b1;
        end else begin
          valid_o <= 1'b1;
          line_o  <= line_i;
          word_o  <= word_i;
          pos_o   <= pos_i;
          kind_o  <= kind_i;
        end
      end else if (ack_i) begin
        valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/l2_ecc_guard.sv
module l2_ecc_guard
  import l2g_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int WORDS = 16,
  parameter int AW    = 40,
  localparam int LINES = SETS * WAYS,
  localparam int LW    = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int SW    = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WYW   = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int OW    = (WORDS > 1) ? $clog2(WORDS) : 1
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_valid,
  input  logic [LW-1:0]    rd_line,
  input  logic [OW-1:0]    rd_word,
  input  logic [AW-1:0]    rd_addr,
  input  logic             rd_dirty,
  input  logic [71:0]      rd_cw,
  output logic             out_valid,
  output logic [63:0]      out_data,
  output logic [1:0]       out_kind,
  output logic [6:0]       out_pos,
  output logic             purge_o,
  output logic             delete_o,
  output logic             refetch_o,
  output logic             wb_bad_o,
  output logic             notify_o,
  output logic [LW-1:0]    ev_line,
  output logic [AW-1:0]    notify_addr,
  output logic [LINES-1:0] dead_mask,
  input  logic             alloc_req,
  input  logic [SW-1:0]    alloc_set,
  output logic             alloc_valid,
  output logic [WYW-1:0]   alloc_way,
  output logic             alloc_miss,
  input  logic             log_ack,
  output logic             log_valid,
  output logic             log_ovf,
  output logic [LW-1:0]    log_line,
  output logic [OW-1:0]    log_word,
  output logic [6:0]       log_pos,
  output logic [1:0]       log_kind
);
  logic [DW-1:0] dec_data;
  err_kind_e     dec_kind;
  logic [PW-1:0] dec_pos;
  logic          is_ce, is_ue, any_err, repeat_hit;

  l2g_secded_dec u_dec (
    .cw_i   (rd_cw),
    .data_o (dec_data),
    .kind_o (dec_kind),
    .pos_o  (dec_pos)
  );

  assign is_ce   = rd_valid && (dec_kind == EK_CE);
  assign is_ue   = rd_valid && (dec_kind == EK_UE);
  assign any_err = is_ce || is_ue;

  l2g_hist #(.LINES(LINES), .LW(LW)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .ce_i     (is_ce),
    .line_i   (rd_line),
    .pos_i    (dec_pos),
    .repeat_o (repeat_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_kind    <= '0;
      out_pos     <= '0;
      purge_o     <= 1'b0;
      delete_o    <= 1'b0;
      refetch_o   <= 1'b0;
      wb_bad_o    <= 1'b0;
      notify_o    <= 1'b0;
      ev_line     <= '0;
      notify_addr <= '0;
      dead_mask   <= '0;
    end else begin
      out_valid <= rd_valid;
      purge_o   <= any_err;
      delete_o  <= repeat_hit;
      refetch_o <= is_ue && !rd_dirty;
      wb_bad_o  <= is_ue && rd_dirty;
      notify_o  <= is_ue && rd_dirty;
      if (rd_valid) begin
        out_data    <= dec_data;
        out_kind    <= dec_kind;
        out_pos     <= dec_pos;
        ev_line     <= rd_line;
        notify_addr <= rd_addr;
      end
      if (repeat_hit) dead_mask[rd_line] <= 1'b1;
    end
  end

  l2g_victim #(.SETS(SETS), .WAYS(WAYS), .SW(SW), .WYW(WYW)) u_victim (
    .clk     (clk),
    .rst     (rst),
    .req_i   (alloc_req),
    .set_i   (alloc_set),
    .dead_i  (dead_mask),
    .valid_o (alloc_valid),
    .way_o   (alloc_way),
    .miss_o  (alloc_miss)
  );

  l2g_log #(.LW(LW), .OW(OW)) u_log (
    .clk     (clk),
    .rst     (rst),
    .err_i   (any_err),
    .kind_i  (dec_kind),
    .line_i  (rd_line),
    .word_i  (rd_word),
    .pos_i   (dec_pos),
    .ack_i   (log_ack),
    .valid_o (log_valid),
    .ovf_o   (log_ovf),
    .line_o  (log_line),
    .word_o  (log_word),
    .pos_o   (log_pos),
    .kind_o  (log_kind)
  );
endmodule

// File: rtl/l2g_checker.sv
module l2g_checker #(
  parameter int LINES = 64,
  parameter int LW    = 6
)(
  input logic             clk,
  input logic             rst,
  input logic             rd_valid,
  input logic             out_valid,
  input logic [1:0]       out_kind,
  input logic             purge_o,
  input logic             delete_o,
  input logic             refetch_o,
  input logic             wb_bad_o,
  input logic             notify_o,
  input logic [LW-1:0]    ev_line,
  input logic [LINES-1:0] dead_mask,
  input logic             alloc_req,
  input logic             alloc_valid,
  input logic             log_valid,
  input logic             log_ovf
);
  AST_CLEAN_QUIET: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind == 2'd0) |-> (!purge_o && !delete_o)); // R1
  AST_PURGE_ON_ERR: assert property (@(posedge clk) disable iff (rst)
    purge_o |-> (out_valid && out_kind != 2'd0)); // R2
  AST_DEL_ON_CE: assert property (@(posedge clk) disable iff (rst)
    delete_o |-> (out_kind == 2'd1 && dead_mask[ev_line])); // R4
  AST_REFETCH_CLEAN: assert property (@(posedge clk) disable iff (rst)
    refetch_o |-> (out_kind == 2'd2 && !wb_bad_o)); // R5
  AST_NOTIFY_UE: assert property (@(posedge clk) disable iff (rst)
    notify_o |-> (out_kind == 2'd2 && purge_o)); // R6
  AST_OVF_HELD: assert property (@(posedge clk) disable iff (rst)
    log_ovf |-> log_valid); // R7
  AST_ALLOC_REPLY: assert property (@(posedge clk) disable iff (rst)
    alloc_valid == $past(alloc_req)); // R8
  AST_MASK_STICKY: assert property (@(posedge clk) disable iff (rst)
    (dead_mask & $past(dead_mask)) == $past(dead_mask)); // R9
  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(rd_valid)); // R10
endmodule

bind l2_ecc_guard l2g_checker #(.LINES(LINES), .LW(LW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rd_valid    (rd_valid),
  .out_valid   (out_valid),
  .out_kind    (out_kind),
  .purge_o     (purge_o),
  .delete_o    (delete_o),
  .refetch_o   (refetch_o),
  .wb_bad_o    (wb_bad_o),
  .notify_o    (notify_o),
  .ev_line     (ev_line),
  .dead_mask   (dead_mask),
  .alloc_req   (alloc_req),
  .alloc_valid (alloc_valid),
  .log_valid   (log_valid),
  .log_ovf     (log_ovf)
);

// File: tb/l2_ecc_guard_tb.sv
module l2_ecc_guard_tb;
  localparam int SETS = 8, WAYS = 4, WORDS = 4, AW = 32;
  localparam int LINES = SETS * WAYS;
  localparam int LW = $clog2(LINES), SW = $clog2(SETS), WYW = $clog2(WAYS), OW = $clog2(WORDS);

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic rd_valid = 0, rd_dirty = 0, alloc_req = 0, log_ack = 0;
  logic [LW-1:0] rd_line = '0;
  logic [OW-1:0] rd_word = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [71:0]   rd_cw = '0;
  logic [SW-1:0] alloc_set = '0;
  logic out_valid, purge_o, delete_o, refetch_o, wb_bad_o, notify_o;
  logic [63:0] out_data;
  logic [1:0] out_kind, log_kind;
  logic [6:0] out_pos, log_pos;
  logic [LW-1:0] ev_line, log_line;
  logic [AW-1:0] notify_addr;
  logic [LINES-1:0] dead_mask;
  logic alloc_valid, alloc_miss, log_valid, log_ovf;
  logic [WYW-1:0] alloc_way;
  logic [OW-1:0] log_word;

  l2_ecc_guard #(.SETS(SETS), .WAYS(WAYS), .WORDS(WORDS), .AW(AW)) u_dut (.*);

  int checks = 0, errors = 0;
  bit m_hv [LINES];
  int m_hb [LINES];
  bit [LINES-1:0] m_mask;
  bit m_lv, m_lovf;
  int m_lline, m_lword, m_lpos, m_lkind;

  task automatic ck(input bit ok, input string req, input string what,
                    input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [71:0] enc(input logic [63:0] d);
    logic [71:0] c = '0;
    int k = 0;
    for (int p = 1; p < 72; p++)
      if ((p & (p - 1)) != 0) begin c[p] = d[k]; k++; end
    for (int i = 0; i < 7; i++) begin
      logic b = 1'b0;
      for (int p = 1; p < 72; p++)
        if (((p >> i) & 1) == 1 && p != (1 << i)) b ^= c[p];
      c[1 << i] = b;
    end
    c[0] = ^c[71:1];
    return c;
  endfunction

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic rd(input int line, input int word, input bit dirty,
                    input logic [63:0] data, input int nflip, input int p1, input int p2);
    logic [71:0] cw = enc(data);
    logic [AW-1:0] addr = AW'($urandom);
    int kind = nflip == 0 ? 0 : (nflip == 1 ? 1 : 2);
    bit rep;
    if (nflip >= 1) cw[p1] = ~cw[p1];
    if (nflip >= 2) cw[p2] = ~cw[p2];
    rep = (kind == 1) && m_hv[line] && (m_hb[line] == p1);
    if (kind == 1) begin m_hv[line] = 1; m_hb[line] = p1; end
    if (rep) m_mask[line] = 1'b1;
    if (kind != 0) begin
      if (m_lv) m_lovf = 1;
      else begin m_lv = 1; m_lline = line; m_lword = word; m_lpos = p1; m_lkind = kind; end
    end
    rd_valid = 1; rd_line = LW'(line); rd_word = OW'(word); rd_dirty = dirty;
    rd_addr = addr; rd_cw = cw;
    @(negedge clk);
    ck(out_valid == 1, "R10", "out_valid", out_valid, 1);
    ck(out_kind == 2'(kind), kind == 0 ? "R1" : (kind == 1 ? "R2" : "R3"), "kind", out_kind, kind);
    if (kind != 2) ck(out_data == data, kind == 0 ? "R1" : "R2", "data", out_data, data);
    if (kind == 1) ck(out_pos == 7'(p1), "R2", "pos", out_pos, p1);
    ck(purge_o == (kind != 0), kind == 2 ? "R3" : "R2", "purge", purge_o, kind != 0);
    ck(delete_o == rep, "R4", "delete", delete_o, rep);
    ck(refetch_o == (kind == 2 && !dirty), "R5", "refetch", refetch_o, kind == 2 && !dirty);
    ck(wb_bad_o == (kind == 2 && dirty), "R6", "wb_bad", wb_bad_o, kind == 2 && dirty);
    ck(notify_o == (kind == 2 && dirty), "R6", "notify", notify_o, kind == 2 && dirty);
    if (kind == 2 && dirty) ck(notify_addr == addr, "R6", "notify_addr", notify_addr, addr);
    ck(dead_mask == m_mask, "R9", "dead_mask", dead_mask, m_mask);
    ck(log_valid == m_lv && log_ovf == m_lovf, "R7", "log flags",
       {log_valid, log_ovf}, {m_lv, m_lovf});
    if (m_lv) begin
      ck(log_line == LW'(m_lline) && log_word == OW'(m_lword) && log_kind == 2'(m_lkind),
         "R7", "log fields", {log_line, log_word, log_kind}, {LW'(m_lline), OW'(m_lword), 2'(m_lkind)});
      if (m_lkind == 1) ck(log_pos == 7'(m_lpos), "R7", "log pos", log_pos, m_lpos);
    end
  endtask

  task automatic idle();
    rd_valid = 0;
    @(negedge clk);
  endtask

  task automatic ack();
    rd_valid = 0; log_ack = 1;
    @(negedge clk);
    log_ack = 0; m_lv = 0; m_lovf = 0;
    ck(log_valid == 0 && log_ovf == 0, "R7", "log after ack", {log_valid, log_ovf}, 0);
  endtask

  task automatic alloc(input int set);
    int ew = 0;
    bit em = 1;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!m_mask[set * WAYS + w]) begin em = 0; ew = w; end
    rd_valid = 0; alloc_req = 1; alloc_set = SW'(set);
    @(negedge clk);
    alloc_req = 0;
    ck(alloc_valid == 1 && alloc_miss == em, "R8", "alloc miss", {alloc_valid, alloc_miss}, {1'b1, em});
    if (!em) ck(alloc_way == WYW'(ew), "R8", "alloc way", alloc_way, ew);
  endtask

  task automatic kill_line(input int line, input int pos);
    rd(line, 0, 0, {$urandom, $urandom}, 1, pos, 0);
    rd(line, 1, 0, {$urandom, $urandom}, 1, pos, 0);
    idle();
    ack();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    void'($urandom(32'd20240513));
    m_mask = '0; m_lv = 0; m_lovf = 0;
    for (int i = 0; i < LINES; i++) begin m_hv[i] = 0; m_hb[i] = 0; end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    ck(out_valid == 0 && dead_mask == 0 && log_valid == 0 && alloc_valid == 0, "R9", "reset",
       {out_valid, log_valid, alloc_valid}, 0);
    // R1 clean words
    rd(1, 0, 0, 64'h0, 0, 0, 0);
    rd(2, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0);
    rd(3, 2, 0, 64'hDEAD_BEEF_0123_4567, 0, 0, 0);
    // R2 single flips: data, check, overall parity, top position
    rd(4, 3, 0, 64'hA5A5_5A5A_0F0F_F0F0, 1, 3, 0);
    rd(5, 0, 0, 64'h1234_5678_9ABC_DEF0, 1, 1, 0);
    rd(6, 1, 0, 64'h0BAD_F00D_CAFE_D00D, 1, 0, 0);
    rd(7, 2, 0, 64'h8000_0000_0000_0001, 1, 71, 0);
    // R3 double flips
    rd(8, 3, 0, 64'h5555_AAAA_5555_AAAA, 2, 0, 40);
    idle();
    ack();
    // R5 and R6
    rd(9, 0, 0, 64'h1111_2222_3333_4444, 2, 10, 20);
    rd(10, 1, 1, 64'h5555_6666_7777_8888, 2, 64, 33);
    idle();
    ack();
    // R4 same bit deletes, different bit does not
    rd(11, 0, 0, 64'h42, 1, 17, 0);
    rd(11, 1, 0, 64'h43, 1, 18, 0);
    rd(11, 2, 0, 64'h44, 1, 18, 0);
    idle();
    ack();
    // R8 victim selection around deleted ways
    for (int w = 0; w < WAYS; w++) kill_line(3 * WAYS + w, 20 + w);
    kill_line(5 * WAYS + 0, 5);
    kill_line(5 * WAYS + 1, 6);
    alloc(3);
    alloc(5);
    alloc(0);
    // random traffic
    for (int n = 0; n < 600; n++) begin
      int r = $urandom_range(0, 9);
      int nf = r < 5 ? 0 : (r < 8 ? 1 : 2);
      int p1 = $urandom_range(0, 71);
      int p2 = (p1 + $urandom_range(1, 71)) % 72;
      int ln = $urandom_range(0, LINES - 1);
      if (nf == 1 && $urandom_range(0, 1) == 1) begin
        ln = $urandom_range(0, 3);
        p1 = $urandom_range(0, 2);
      end
      rd(ln, $urandom_range(0, WORDS - 1), 1'($urandom), {$urandom, $urandom}, nf, p1, p2);
      if ($urandom_range(0, 7) == 0) begin idle(); ack(); end
      if ($urandom_range(0, 9) == 0) alloc($urandom_range(0, SETS - 1));
    end
    idle();
    finish_up();
  end
endmodule